// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller keep running while it sleeps. Firmware selects a sleep mode in a 3-bit field, sets the sleep enable and raises a sleep request. The controller then gates five enables: the CPU clock, the I/O peripheral clock, the converter clock, the asynchronous timer clock and the main oscillator. Each mode has its own set of live domains.

The controller leaves sleep when a permitted interrupt request arrives, or when reset is applied. Requests come in as a masked bus, one bit per source, with a tag bus that marks the sources able to run without the main clock. After a wake from a mode that stopped the oscillator, the CPU clock stays gated for a programmable settle time. The two standby modes keep the oscillator running, so they resume after a short fixed wait.

Top module: `slpctl_top`

## Requirements
- R1: While reset is low, and right after it, all five enables are high.
- R2: A sleep request is ignored when sleep enable is low in the same cycle, and all enables stay high.
- R3: Mode 000 (Idle) turns off only the CPU clock. The reserved codes 100 and 101 behave exactly as Idle.
- R4: Mode 001 (converter quiet) turns off the CPU and I/O clocks. The converter clock, the timer clock and the oscillator stay on.
- R5: Mode 010 (Power-down) turns all five enables off.
- R6: Mode 011 (Power-save) keeps only the asynchronous timer clock on.
- R7: Mode 110 (Standby) keeps only the oscillator on. Mode 111 (Extended Standby) keeps the oscillator and the asynchronous timer clock on.
- R8: In Power-down and Power-save, a request whose tag bit is 0 does not wake the block. A request whose tag bit is 1 does wake it.
- R9: In Idle, converter quiet, Standby and Extended Standby, any request wakes the block, whatever its tag.
- R10: On a wake from Power-down or Power-save with settle count D, the oscillator turns on at once. The CPU clock then stays off for exactly D cycles after the waking edge. With D = 0 all enables are high one cycle after the waking edge.
- R11: On a wake from Standby or Extended Standby, the CPU clock stays off for exactly FIXED_WAIT cycles (default 6).
- R12: On a wake from Idle or converter quiet, all enables are high one cycle after the waking edge.
- R13: Reset low during sleep or during the settle wait forces all enables high at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_en | input | 1 | Sleep enable, qualifies the request |
| sleep_req | input | 1 | Sleep request pulse |
| mode_sel | input | 3 | Sleep mode code |
| startup_cnt | input | DLY_W (16) | Settle count D used after an oscillator-off wake |
| irq_req | input | NSRC (8) | Masked interrupt requests |
| irq_async | input | NSRC (8) | Per-source tag, 1 means the source can wake the block with the oscillator stopped |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O peripheral clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| atmr_clk_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |

## Verification
The hardest situation to reach is the settle wait, where the oscillator is already on but the CPU clock is still gated. The wait lasts only D cycles and only follows a tagged request in an oscillator-off mode. The bench first holds an untagged request in Power-down and checks that nothing changes. It then raises a tagged source with a chosen D and checks the CPU enable on every cycle of the window, including its last gated cycle and its first live one. A second run pulls reset low in the middle of the wait, so that the asynchronous reset path is tested on a non-idle state.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'b000,
    MD_ADCNR = 3'b001,
    MD_PDOWN = 3'b010,
    MD_PSAVE = 3'b011,
    MD_STBY  = 3'b110,
    MD_XSTBY = 3'b111
  } slp_mode_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic atmr;
    logic osc;
  } gate_t;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WARM   = 2'd2
  } slp_state_e;

  localparam gate_t GATES_ALL_ON = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, atmr: 1'b1, osc: 1'b1};

  // reserved codes fold onto Idle
  function automatic slp_mode_e norm_mode(input logic [2:0] raw);
    case (raw)
      3'b001:  return MD_ADCNR;
      3'b010:  return MD_PDOWN;
      3'b011:  return MD_PSAVE;
      3'b110:  return MD_STBY;
      3'b111:  return MD_XSTBY;
      default: return MD_IDLE;
    endcase
  endfunction

  function automatic gate_t mode_gates(input slp_mode_e m);
    gate_t g;
    g = '0;
    case (m)
      MD_IDLE:  begin g.io = 1'b1; g.adc = 1'b1; g.atmr = 1'b1; g.osc = 1'b1; end
      MD_ADCNR: begin g.adc = 1'b1; g.atmr = 1'b1; g.osc = 1'b1; end
      MD_PSAVE: begin g.atmr = 1'b1; end
      MD_STBY:  begin g.osc = 1'b1; end
      MD_XSTBY: begin g.atmr = 1'b1; g.osc = 1'b1; end
      default:  g = '0;
    endcase
    return g;
  endfunction

  function automatic logic osc_stopped(input slp_mode_e m);
    return (m == MD_PDOWN) || (m == MD_PSAVE);
  endfunction

  function automatic logic fast_resume(input slp_mode_e m);
    return (m == MD_STBY) || (m == MD_XSTBY);
  endfunction

endpackage

// File: rtl/slpctl_decode.sv
module slpctl_decode
  import slpctl_pkg::*;
(
  input  slp_mode_e mode,
  output gate_t     gates,
  output logic      osc_stop,
  output logic      fast
);
  always_comb begin
    gates    = mode_gates(mode);
    osc_stop = osc_stopped(mode);
    fast     = fast_resume(mode);
  end
endmodule

// File: rtl/slpctl_wake.sv
module slpctl_wake #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic            restricted,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_async,
  output logic            wake_hit
);
  function automatic logic [NSRC-1:0] legal_srcs(input logic [NSRC-1:0] req,
                                                 input logic [NSRC-1:0] tag,
                                                 input logic            only_async);
    return only_async ? (req & tag) : req;
  endfunction

  logic [NSRC-1:0] legal_req;
  assign legal_req = legal_srcs(irq_req, irq_async, restricted);
  assign wake_hit  = armed && (|legal_req);

  // R8
  untagged_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && restricted) |-> (|(irq_req & irq_async)));
endmodule

// File: rtl/slpctl_timer.sv
module slpctl_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      busy  <= 1'b1;
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  assign done = busy && (cnt_q == '0);

  // R10
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && cnt_q == $past(load_val)));
  // R10
  timer_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy);
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
  import slpctl_pkg::*;
#(
  parameter int NSRC       = 8,
  parameter int DLY_W      = 16,
  parameter int FIXED_WAIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_en,
  input  logic             sleep_req,
  input  logic [2:0]       mode_sel,
  input  logic [DLY_W-1:0] startup_cnt,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_async,
  output logic             cpu_clk_en,
  output logic             io_clk_en,
  output logic             adc_clk_en,
  output logic             atmr_clk_en,
  output logic             osc_en
);
  localparam logic [DLY_W-1:0] FIXED_LOAD = DLY_W'(FIXED_WAIT - 1);

  slp_state_e       state_q, state_d;
  slp_mode_e        mode_q;
  gate_t            dec_gates, gates;
  logic             dec_osc_stop, dec_fast;
  logic             accept, wake_hit;
  logic             tmr_load, tmr_busy, tmr_done;
  logic [DLY_W-1:0] tmr_val;

  slpctl_decode u_decode (
    .mode     (mode_q),
    .gates    (dec_gates),
    .osc_stop (dec_osc_stop),
    .fast     (dec_fast)
  );

  slpctl_wake #(.NSRC(NSRC)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (state_q == ST_SLEEP),
    .restricted (dec_osc_stop),
    .irq_req    (irq_req),
    .irq_async  (irq_async),
    .wake_hit   (wake_hit)
  );

  slpctl_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .busy     (tmr_busy),
    .done     (tmr_done)
  );

  assign accept = (state_q == ST_ACTIVE) && sleep_req && sleep_en;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_ACTIVE: if (accept) state_d = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_hit) begin
          if (dec_osc_stop) begin
            if (startup_cnt == '0) begin
              state_d = ST_ACTIVE;
            end else begin
              tmr_load = 1'b1;
              tmr_val  = startup_cnt - DLY_W'(1);
              state_d  = ST_WARM;
            end
          end else if (dec_fast) begin
            tmr_load = 1'b1;
            tmr_val  = FIXED_LOAD;
            state_d  = ST_WARM;
          end else begin
            state_d = ST_ACTIVE;
          end
        end
      end
      ST_WARM: if (tmr_done) state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      mode_q  <= MD_IDLE;
    end else begin
      state_q <= state_d;
      if (accept) mode_q <= norm_mode(mode_sel);
    end
  end

  always_comb begin
    case (state_q)
      ST_SLEEP: gates = dec_gates;
      ST_WARM: begin
        gates     = dec_gates;
        gates.cpu = 1'b0;
        gates.osc = 1'b1;
      end
      default: gates = GATES_ALL_ON;
    endcase
  end

  assign cpu_clk_en  = gates.cpu;
  assign io_clk_en   = gates.io;
  assign adc_clk_en  = gates.adc;
  assign atmr_clk_en = gates.atmr;
  assign osc_en      = gates.osc;

  // R2
  ignore_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && sleep_req && !sleep_en) |=> (state_q == ST_ACTIVE));
  // R3
  cpu_stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(sleep_req && sleep_en));
  // R5
  osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !io_clk_en && !adc_clk_en));
  // R10
  warm_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WARM) |-> tmr_busy);
endmodule

// File: tb/slpctl_top_tb_top.sv
module slpctl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int DLY_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sleep_en = 1'b0;
  logic             sleep_req = 1'b0;
  logic [2:0]       mode_sel = 3'b000;
  logic [DLY_W-1:0] startup_cnt = '0;
  logic [NSRC-1:0]  irq_req = '0;
  logic [NSRC-1:0]  irq_async = 8'b1000_0000;
  logic cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slpctl_top #(.NSRC(NSRC), .DLY_W(DLY_W), .FIXED_WAIT(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_req(sleep_req),
    .mode_sel(mode_sel), .startup_cnt(startup_cnt), .irq_req(irq_req),
    .irq_async(irq_async), .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en),
    .adc_clk_en(adc_clk_en), .atmr_clk_en(atmr_clk_en), .osc_en(osc_en)
  );

  function automatic logic [4:0] gates();
    return {cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en};
  endfunction

  task automatic chk(input logic [4:0] exp, input string req);
    checks++;
    if (gates() !== exp) begin
      errors++;
      $display("FAIL %s: gates {cpu,io,adc,atmr,osc} actual %b expected %b", req, gates(), exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sleep_req = 1'b0; irq_req = '0;
    repeat (2) @(negedge clk);
    chk(5'b11111, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(5'b11111, "R1 after reset");
  endtask

  task automatic enter(input logic [2:0] m);
    @(negedge clk);
    mode_sel = m; sleep_en = 1'b1; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  // drive a request, then check n gated cycles followed by all-on
  task automatic wake(input logic [NSRC-1:0] src, input int n, input string req);
    irq_req = src;
    @(negedge clk);
    irq_req = '0;
    for (int i = 0; i < n; i++) begin
      checks++;
      if (!(cpu_clk_en === 1'b0 && osc_en === 1'b1)) begin
        errors++;
        $display("FAIL %s: wait cycle %0d cpu/osc actual %b%b expected 01", req, i, cpu_clk_en, osc_en);
      end
      @(negedge clk);
    end
    chk(5'b11111, req);
  endtask

  task automatic t_no_enable();
    @(negedge clk);
    mode_sel = 3'b010; sleep_en = 1'b0; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(5'b11111, "R2");
    @(negedge clk);
    chk(5'b11111, "R2 later");
  endtask

  task automatic t_idle_like(input logic [2:0] m);
    enter(m);
    chk(5'b01111, "R3");
    wake(8'b0000_0001, 0, "R9 R12 idle untagged wake");
  endtask

  task automatic t_adcnr();
    enter(3'b001);
    chk(5'b00111, "R4");
    wake(8'b0000_0010, 0, "R9 R12 converter quiet wake");
  endtask

  task automatic t_pdown();
    startup_cnt = 16'd4;
    enter(3'b010);
    chk(5'b00000, "R5");
    irq_req = 8'b0000_0011;
    repeat (3) @(negedge clk);
    chk(5'b00000, "R8 untagged ignored");
    irq_req = '0;
    @(negedge clk);
    wake(8'b1000_0000, 4, "R10 D=4");
  endtask

  task automatic t_psave();
    startup_cnt = 16'd0;
    enter(3'b011);
    chk(5'b00010, "R6");
    irq_req = 8'b0000_0100;
    @(negedge clk);
    chk(5'b00010, "R8 untagged in power-save");
    wake(8'b1000_0000, 0, "R10 D=0");
  endtask

  task automatic t_standby(input logic [2:0] m, input logic [4:0] exp);
    startup_cnt = 16'd50;
    enter(m);
    chk(exp, "R7");
    wake(8'b0000_0001, 6, "R9 R11 fixed wait");
  endtask

  task automatic t_reset_sleep();
    enter(3'b010);
    chk(5'b00000, "R5 before reset");
    rst_n = 1'b0;
    #1;
    chk(5'b11111, "R13 reset in sleep");
    @(negedge clk);
    rst_n = 1'b1;
    startup_cnt = 16'd20;
    enter(3'b011);
    irq_req = 8'b1000_0000;
    @(negedge clk);
    irq_req = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (cpu_clk_en !== 1'b0) begin
      errors++;
      $display("FAIL R10: cpu actual %b expected 0 mid wait", cpu_clk_en);
    end
    rst_n = 1'b0;
    #1;
    chk(5'b11111, "R13 reset in wait");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(5'b11111, "R13 after release");
  endtask

  initial begin
    do_reset();
    t_no_enable();
    t_idle_like(3'b000);
    t_idle_like(3'b100);
    t_idle_like(3'b101);
    t_adcnr();
    t_pdown();
    t_psave();
    t_standby(3'b110, 5'b00001);
    t_standby(3'b111, 5'b00011);
    t_reset_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles actual %0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule